// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic datapath of a small accumulator-style microcontroller core. It takes a working-register operand `w_in` and a second operand `f_in` (a file register or a literal) and produces an 8-bit result from a 4-bit operation code. The result depends combinationally on the operands, the operation code and the stored carry and digit-carry flags. An unsigned 16-bit product of the two operands is always present on its own pair of byte outputs. Three unsigned compare outputs are also always present.

The five status flags are carry, digit carry, overflow, zero and negative. They live in a register inside the block. On a clock edge with `flag_we` high, each operation loads only the flags that it affects. The stored carry and digit carry feed back into add-with-carry, subtract-with-borrow, the rotates through carry and the decimal adjust, so multi-byte arithmetic can be chained one operation per cycle. Instruction decode, fetch and the register file are outside the block.

Top module: `alu8_core`

## Requirements
- R1: ADD (op 0) gives `f_in + w_in`. ADDC (op 1) gives `f_in + w_in + C`. C becomes bit 8 of the 9-bit sum. Chaining the low byte 0x8D+0xE7 (result 0x74, C=1) into ADDC of the high bytes 0x3B+0x3C gives 0x78.
- R2: SUB (op 2) gives `f_in + ~w_in + 1`. SUBB (op 3) gives `f_in + ~w_in + C`. C=1 means that no borrow occurred.
- R3: For ops 0 to 4, OV is set exactly when the carry into bit 7 differs from the carry out of bit 7.
- R4: For ops 0 to 4, DC is the carry out of bit 3 and Z is set when the 8-bit result is zero. N is bit 7 of the result.
- R5: NEG (op 4) gives the two's complement of `f_in` (computed as `0 + ~f_in + 1`) and updates all five flags. COM (op 5) gives `~f_in` and updates only Z and N.
- R6: AND (op 6), OR (op 7) and XOR (op 8) combine `f_in` with `w_in`. They update only Z and N, and C, DC and OV keep their values.
- R7: RLNC (op 9) and RRNC (op 10) rotate `f_in` left or right within the byte and update Z and N. RLC (op 11) and RRC (op 12) rotate through a 9-bit ring with C, so the bit shifted out lands in C. They update C, Z and N.
- R8: SWAP (op 13) exchanges the two nibbles of `f_in` and changes no flag.
- R9: DAW (op 14) adjusts `w_in` to packed BCD. It adds 0x06 when the low nibble exceeds 9 or DC is set. It then adds 0x60 when the upper nibble of that partial result exceeds 9, or when C is set, or when the first step carried out. C becomes the OR of the old C and both step carries. DAW updates only C. For example, 0x47+0x25 gives 0x6C, and DAW then gives 0x72.
- R10: `{prod_hi, prod_lo}` always equals the unsigned product `w_in * f_in`. MUL (op 15) puts the low byte on `result` and changes no flag.
- R11: `cmp_gt`, `cmp_eq` and `cmp_lt` report the unsigned relations `f_in > w_in`, `f_in == w_in` and `f_in < w_in`. Exactly one of them is high, whatever the op.
- R12: The flags reset to zero. They change only on a rising clock edge with `flag_we` high, and only the flags that the op affects are updated. The flag outputs are ordered C, DC, OV, Z, N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| flag_we | input | 1 | Commit the op's flag update at this edge |
| op | input | 4 | Operation code, 0 to 15 |
| w_in | input | 8 | Working-register operand |
| f_in | input | 8 | File-register or literal operand |
| result | output | 8 | Operation result |
| prod_hi | output | 8 | Upper byte of `w_in * f_in` |
| prod_lo | output | 8 | Lower byte of `w_in * f_in` |
| cmp_gt | output | 1 | `f_in > w_in`, unsigned |
| cmp_eq | output | 1 | `f_in == w_in` |
| cmp_lt | output | 1 | `f_in < w_in`, unsigned |
| c_flag | output | 1 | Stored carry |
| dc_flag | output | 1 | Stored digit carry |
| ov_flag | output | 1 | Stored signed overflow |
| z_flag | output | 1 | Stored zero flag |
| n_flag | output | 1 | Stored negative flag |

## Verification
The assertions assume that `op`, `w_in`, `f_in` and `flag_we` are stable around the rising edge, so that the `$past` of an operand matches the value that produced the stored flags. The bench changes every input only on the falling edge and holds it through the following rising edge. Because flags can be loaded only through operations, each table vector first runs a priming ADD. That ADD leaves C and DC both 0 or both 1, and the vector's expected flags are written against that known start state.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W  = 8;
  localparam int NIB_W   = DATA_W / 2;
  localparam int FLAG_N  = 5;
  // flag vector bit positions: {C, DC, OV, Z, N}
  localparam int FL_C  = 4;
  localparam int FL_DC = 3;
  localparam int FL_OV = 2;
  localparam int FL_Z  = 1;
  localparam int FL_N  = 0;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBB = 4'd3,
    OP_NEG  = 4'd4,  OP_COM  = 4'd5,  OP_AND  = 4'd6,  OP_OR   = 4'd7,
    OP_XOR  = 4'd8,  OP_RLNC = 4'd9,  OP_RRNC = 4'd10, OP_RLC  = 4'd11,
    OP_RRC  = 4'd12, OP_SWAP = 4'd13, OP_DAW  = 4'd14, OP_MUL  = 4'd15
  } alu_op_e;

  // Which flags an op is allowed to write, {C, DC, OV, Z, N}
  function automatic logic [FLAG_N-1:0] flag_mask(alu_op_e op);
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_NEG: flag_mask = 5'b11111;
      OP_COM, OP_AND, OP_OR, OP_XOR,
      OP_RLNC, OP_RRNC:                         flag_mask = 5'b00011;
      OP_RLC, OP_RRC:                           flag_mask = 5'b10011;
      OP_DAW:                                   flag_mask = 5'b10000;
      default:                                  flag_mask = 5'b00000;
    endcase
  endfunction

  // Packed-BCD correction: returns {carry, adjusted byte}
  function automatic logic [DATA_W:0] dec_adjust(logic [DATA_W-1:0] v,
                                                 logic c_in, logic dc_in);
    logic [DATA_W:0] step1;
    logic [DATA_W:0] step2;
    logic            lo_fix;
    logic            hi_fix;
    lo_fix = (v[NIB_W-1:0] > 4'd9) || dc_in;
    step1  = {1'b0, v} + (lo_fix ? 9'h006 : 9'h000);
    hi_fix = (step1[DATA_W-1:NIB_W] > 4'd9) || c_in || step1[DATA_W];
    step2  = {1'b0, step1[DATA_W-1:0]} + (hi_fix ? 9'h060 : 9'h000);
    dec_adjust = {c_in | step1[DATA_W] | step2[DATA_W], step2[DATA_W-1:0]};
  endfunction
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             c_half,
  output logic             c_msb_in
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH:0] full_sum;
  logic [HALF:0]  low_sum;

  assign full_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
  assign low_sum  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};

  assign sum      = full_sum[WIDTH-1:0];
  assign cout     = full_sum[WIDTH];
  assign c_half   = low_sum[HALF];
  assign c_msb_in = full_sum[WIDTH-1] ^ a[WIDTH-1] ^ b[WIDTH-1];
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] w,
  input  logic [DATA_W-1:0] f,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  always_comb begin
    res  = f;
    cout = cin;
    case (op)
      OP_COM:  res = ~f;
      OP_AND:  res = f & w;
      OP_OR:   res = f | w;
      OP_XOR:  res = f ^ w;
      OP_RLNC: res = {f[DATA_W-2:0], f[DATA_W-1]};
      OP_RRNC: res = {f[0], f[DATA_W-1:1]};
      OP_RLC: begin
        res  = {f[DATA_W-2:0], cin};
        cout = f[DATA_W-1];
      end
      OP_RRC: begin
        res  = {cin, f[DATA_W-1:1]};
        cout = f[0];
      end
      OP_SWAP: res = {f[NIB_W-1:0], f[DATA_W-1:NIB_W]};
      default: res = f;
    endcase
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [FLAG_N-1:0] mask,
  input  logic [FLAG_N-1:0] nxt,
  output logic [FLAG_N-1:0] q
);
  for (genvar i = 0; i < FLAG_N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (we && mask[i])
        q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flag_we,
  input  logic [3:0] op,
  input  logic [7:0] w_in,
  input  logic [7:0] f_in,
  output logic [7:0] result,
  output logic [7:0] prod_hi,
  output logic [7:0] prod_lo,
  output logic       cmp_gt,
  output logic       cmp_eq,
  output logic       cmp_lt,
  output logic       c_flag,
  output logic       dc_flag,
  output logic       ov_flag,
  output logic       z_flag,
  output logic       n_flag
);
  alu_op_e             op_e;
  logic [FLAG_N-1:0]   flags_q;
  logic [FLAG_N-1:0]   flags_nxt;
  logic [DATA_W-1:0]   add_a, add_b, add_sum;
  logic                add_ci, add_co, add_dc, add_c7;
  logic [DATA_W-1:0]   bit_res;
  logic                bit_co;
  logic [DATA_W:0]     daw_out;
  logic [2*DATA_W-1:0] prod_full;
  logic                is_arith;

  assign op_e = alu_op_e'(op);

  // Adder operand steering: subtraction is addition of the inverted W
  always_comb begin
    add_a  = f_in;
    add_b  = w_in;
    add_ci = 1'b0;
    case (op_e)
      OP_ADDC: add_ci = flags_q[FL_C];
      OP_SUB: begin
        add_b  = ~w_in;
        add_ci = 1'b1;
      end
      OP_SUBB: begin
        add_b  = ~w_in;
        add_ci = flags_q[FL_C];
      end
      OP_NEG: begin
        add_a  = '0;
        add_b  = ~f_in;
        add_ci = 1'b1;
      end
      default: ;
    endcase
  end

  alu8_adder #(.WIDTH(DATA_W)) u_adder (
    .a(add_a), .b(add_b), .cin(add_ci),
    .sum(add_sum), .cout(add_co), .c_half(add_dc), .c_msb_in(add_c7)
  );

  alu8_bitops u_bitops (
    .op(op_e), .w(w_in), .f(f_in), .cin(flags_q[FL_C]),
    .res(bit_res), .cout(bit_co)
  );

  assign daw_out   = dec_adjust(w_in, flags_q[FL_C], flags_q[FL_DC]);
  assign prod_full = {{DATA_W{1'b0}}, w_in} * {{DATA_W{1'b0}}, f_in};
  assign is_arith  = (op_e == OP_ADD) || (op_e == OP_ADDC) || (op_e == OP_SUB) ||
                     (op_e == OP_SUBB) || (op_e == OP_NEG);

  always_comb begin
    if (is_arith)
      result = add_sum;
    else if (op_e == OP_DAW)
      result = daw_out[DATA_W-1:0];
    else if (op_e == OP_MUL)
      result = prod_full[DATA_W-1:0];
    else
      result = bit_res;
  end

  always_comb begin
    flags_nxt        = flags_q;
    flags_nxt[FL_Z]  = (result == '0);
    flags_nxt[FL_N]  = result[DATA_W-1];
    if (is_arith) begin
      flags_nxt[FL_C]  = add_co;
      flags_nxt[FL_DC] = add_dc;
      flags_nxt[FL_OV] = add_c7 ^ add_co;
    end else if (op_e == OP_DAW) begin
      flags_nxt[FL_C]  = daw_out[DATA_W];
    end else begin
      flags_nxt[FL_C]  = bit_co;
    end
  end

  alu8_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we),
    .mask(flag_mask(op_e)), .nxt(flags_nxt), .q(flags_q)
  );

  assign prod_hi = prod_full[2*DATA_W-1:DATA_W];
  assign prod_lo = prod_full[DATA_W-1:0];
  assign cmp_gt  = f_in > w_in;
  assign cmp_eq  = f_in == w_in;
  assign cmp_lt  = f_in < w_in;
  assign c_flag  = flags_q[FL_C];
  assign dc_flag = flags_q[FL_DC];
  assign ov_flag = flags_q[FL_OV];
  assign z_flag  = flags_q[FL_Z];
  assign n_flag  = flags_q[FL_N];
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_we,
  input logic [3:0] op,
  input logic [7:0] w_in,
  input logic [7:0] f_in,
  input logic [7:0] result,
  input logic       cmp_gt,
  input logic       cmp_eq,
  input logic       cmp_lt,
  input logic       c_flag,
  input logic       dc_flag,
  input logic       ov_flag,
  input logic       z_flag,
  input logic       n_flag
);
  logic [4:0] flv;
  assign flv = {c_flag, dc_flag, ov_flag, z_flag, n_flag};

  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flv));

  // R10
  mul_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op == 4'd15) |=> $stable(flv));

  // R6
  logic_keeps_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op inside {4'd5, 4'd6, 4'd7, 4'd8}) |=> $stable({c_flag, dc_flag, ov_flag}));

  // R8
  swap_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op == 4'd13) |=> $stable(flv));

  // R11
  one_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmp_gt, cmp_eq, cmp_lt}) == 1);

  // R3
  add_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op == 4'd0 && w_in[7] == f_in[7])
      |=> ov_flag == ($past(result[7]) != $past(w_in[7])));

  // R4
  arith_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4})
      |=> (z_flag == ($past(result) == 8'h00)) && (n_flag == $past(result[7])));
endmodule

bind alu8_core alu8_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .op(op), .w_in(w_in), .f_in(f_in),
  .result(result), .cmp_gt(cmp_gt), .cmp_eq(cmp_eq), .cmp_lt(cmp_lt),
  .c_flag(c_flag), .dc_flag(dc_flag), .ov_flag(ov_flag), .z_flag(z_flag), .n_flag(n_flag)
);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flag_we = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] w_in = 8'h00, f_in = 8'h00;
  logic [7:0] result, prod_hi, prod_lo;
  logic       cmp_gt, cmp_eq, cmp_lt;
  logic       c_flag, dc_flag, ov_flag, z_flag, n_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core u_alu8_core (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .op(op), .w_in(w_in), .f_in(f_in),
    .result(result), .prod_hi(prod_hi), .prod_lo(prod_lo),
    .cmp_gt(cmp_gt), .cmp_eq(cmp_eq), .cmp_lt(cmp_lt),
    .c_flag(c_flag), .dc_flag(dc_flag), .ov_flag(ov_flag), .z_flag(z_flag), .n_flag(n_flag)
  );

  // {op, w, f, start carry, expected result, expected flags {C,DC,OV,Z,N}}
  localparam logic [33:0] VEC [NVEC] = '{
    {4'd0,  8'h8D, 8'hE7, 1'b0, 8'h74, 5'b11100},
    {4'd1,  8'h3C, 8'h3B, 1'b1, 8'h78, 5'b01000},
    {4'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 5'b01101},
    {4'd2,  8'h05, 8'h03, 1'b0, 8'hFE, 5'b00001},
    {4'd2,  8'h03, 8'h05, 1'b0, 8'h02, 5'b11000},
    {4'd2,  8'h42, 8'h42, 1'b0, 8'h00, 5'b11010},
    {4'd3,  8'h01, 8'h10, 1'b0, 8'h0E, 5'b10000},
    {4'd3,  8'h01, 8'h10, 1'b1, 8'h0F, 5'b10000},
    {4'd4,  8'h00, 8'h01, 1'b0, 8'hFF, 5'b00001},
    {4'd4,  8'h00, 8'h80, 1'b0, 8'h80, 5'b01101},
    {4'd4,  8'h00, 8'h00, 1'b0, 8'h00, 5'b11010},
    {4'd5,  8'h00, 8'h5A, 1'b1, 8'hA5, 5'b11001},
    {4'd6,  8'hF0, 8'h0F, 1'b0, 8'h00, 5'b00010},
    {4'd7,  8'h80, 8'h01, 1'b1, 8'h81, 5'b11001},
    {4'd8,  8'hFF, 8'hFF, 1'b1, 8'h00, 5'b11010},
    {4'd9,  8'h00, 8'h81, 1'b0, 8'h03, 5'b00000},
    {4'd10, 8'h00, 8'h01, 1'b0, 8'h80, 5'b00001},
    {4'd11, 8'h00, 8'h80, 1'b0, 8'h00, 5'b10010},
    {4'd11, 8'h00, 8'h00, 1'b1, 8'h01, 5'b01000},
    {4'd12, 8'h00, 8'h01, 1'b1, 8'h80, 5'b11001},
    {4'd12, 8'h00, 8'h02, 1'b0, 8'h01, 5'b00000},
    {4'd13, 8'h00, 8'hA5, 1'b1, 8'h5A, 5'b11001},
    {4'd14, 8'h6C, 8'h00, 1'b0, 8'h72, 5'b00010},
    {4'd14, 8'h9A, 8'h00, 1'b0, 8'h00, 5'b10010},
    {4'd14, 8'h41, 8'h00, 1'b1, 8'hA7, 5'b11001},
    {4'd15, 8'hFF, 8'hFF, 1'b0, 8'h01, 5'b00010},
    {4'd15, 8'h10, 8'h20, 1'b1, 8'h00, 5'b11001}
  };

  function automatic string req_of(logic [3:0] o);
    case (o)
      4'd0, 4'd1:          req_of = "R1";
      4'd2, 4'd3:          req_of = "R2";
      4'd4, 4'd5:          req_of = "R5";
      4'd6, 4'd7, 4'd8:    req_of = "R6";
      4'd9, 4'd10, 4'd11, 4'd12: req_of = "R7";
      4'd13:               req_of = "R8";
      4'd14:               req_of = "R9";
      default:             req_of = "R10";
    endcase
  endfunction

  task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  logic [7:0] r_seen, ph_seen, pl_seen;
  logic [2:0] cmp_seen;

  // Drive on the falling edge, sample combinational outputs 1 time unit later,
  // then sample the flags just after the rising edge.
  task automatic do_op(logic [3:0] o, logic [7:0] w, logic [7:0] f, logic we);
    @(negedge clk);
    op = o; w_in = w; f_in = f; flag_we = we;
    #1;
    r_seen   = result;
    ph_seen  = prod_hi;
    pl_seen  = prod_lo;
    cmp_seen = {cmp_gt, cmp_eq, cmp_lt};
    @(posedge clk);
    #1;
  endtask

  task automatic prime(logic cin);
    if (cin) do_op(4'd0, 8'hFF, 8'hFF, 1'b1);
    else     do_op(4'd0, 8'h00, 8'h00, 1'b1);
  endtask

  function automatic logic [4:0] flags_now();
    flags_now = {c_flag, dc_flag, ov_flag, z_flag, n_flag};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R12", "flags in reset", {11'd0, flags_now()}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R12", "flags after reset", {11'd0, flags_now()}, 16'h0000);

    // Table walk: R3 and R4 flag behaviour is covered by the arithmetic rows
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] vo;
      logic [7:0] vw, vf, vr;
      logic       vc;
      logic [4:0] vfl;
      logic [15:0] pexp;
      logic [2:0] cexp;
      {vo, vw, vf, vc, vr, vfl} = VEC[i];
      prime(vc);
      do_op(vo, vw, vf, 1'b1);
      pexp = 16'(vw) * 16'(vf);
      cexp = {vf > vw, vf == vw, vf < vw};
      check(req_of(vo), "result", {8'd0, r_seen}, {8'd0, vr});
      check({req_of(vo), " R3 R4 R12"}, "flags", {11'd0, flags_now()}, {11'd0, vfl});
      check("R10", "product", {ph_seen, pl_seen}, pexp);
      check("R11", "compare", {13'd0, cmp_seen}, {13'd0, cexp});
    end

    // R1 chained two-byte addition 0x3B8D + 0x3CE7
    prime(1'b0);
    do_op(4'd0, 8'hE7, 8'h8D, 1'b1);
    check("R1", "low byte sum", {8'd0, r_seen}, 16'h0074);
    check("R1", "low byte carry", {15'd0, c_flag}, 16'h0001);
    do_op(4'd1, 8'h3C, 8'h3B, 1'b1);
    check("R1", "high byte sum", {8'd0, r_seen}, 16'h0078);

    // R9 add then adjust 0x47 + 0x25
    do_op(4'd0, 8'h25, 8'h47, 1'b1);
    check("R9", "binary sum", {8'd0, r_seen}, 16'h006C);
    do_op(4'd14, r_seen, 8'h00, 1'b1);
    check("R9", "adjusted", {8'd0, r_seen}, 16'h0072);

    // R12 flags ignore an update without flag_we
    prime(1'b1);
    do_op(4'd0, 8'h00, 8'h00, 1'b0);
    check("R12", "hold without strobe", {11'd0, flags_now()}, 16'h0019);

    // R11 unsigned compare boundaries
    do_op(4'd6, 8'hFF, 8'h00, 1'b0);
    check("R11", "0x00 vs 0xFF", {13'd0, cmp_seen}, 16'h0001);
    do_op(4'd6, 8'h00, 8'h80, 1'b0);
    check("R11", "0x80 vs 0x00", {13'd0, cmp_seen}, 16'h0004);

    // R10 largest product
    do_op(4'd15, 8'hFF, 8'hFE, 1'b0);
    check("R10", "product 0xFF*0xFE", {ph_seen, pl_seen}, 16'hFD02);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule